// File: doc/BRIEF.md
# Masked Bus Pattern Trigger

This block watches a parallel bus made of an address field and a data field, plus an access strobe. When a bus access matches a programmable bit pattern, it emits a single one-clock trigger pulse. The pulse is meant to drive the external trigger input of an oscilloscope. Its timing is therefore fixed relative to the bus cycle that caused it, so that repeated runs of the same access sequence line up on the screen.

Each bus bit has a reference value and a compare enable. An enabled bit compares the captured bus bit against its reference. A disabled bit does not mask the comparison. Instead, the monitored side of that bit floats to a pulled-up logic 1, so it matches only when its reference bit is also 1. Software must therefore program the reference to 1 for every bit it wants ignored.

All inputs, including the pattern, are registered before the compare. A three-state machine turns the level match into a pulse. The states are ST_WAIT (armed, no match seen), ST_FIRE (the pulse cycle) and ST_HOLD (the match persists, no further pulse). The transitions are:
- ST_WAIT→ST_FIRE on a match.
- ST_FIRE→ST_HOLD while the match stays true.
- ST_FIRE→ST_WAIT when the match drops.
- ST_HOLD→ST_WAIT when the match drops.
- ST_HOLD stays in ST_HOLD while the match holds.

A synchronous reset returns the machine to ST_WAIT.

Top module: `bus_pattern_trigger`

## Requirements
- R1: While `rst` is high at a rising edge, the capture registers and the edge state are cleared. `trig_out` is 0 from the following cycle. A match still present when reset is released yields a fresh pulse.
- R2: The bus word is {addr_in, data_in}, with addr_in in the upper bits. Bit i of `pat_ref` and bit i of `pat_care` belong to bit i of that word. For a bit with `pat_care`[i]=1, the captured bus bit must equal `pat_ref`[i] for a match.
- R3: For a bit with `pat_care`[i]=0, the compared value is a constant 1. That bit matches when `pat_ref`[i]=1 and never matches when `pat_ref`[i]=0, whatever the bus bit is.
- R4: No match is seen for a cycle in which `bus_strobe` was low, even if every bus bit agrees with the pattern.
- R5: `trig_out` is never high in two consecutive cycles.
- R6: A match that stays true for several consecutive cycles produces exactly one pulse. A new pulse needs the match to be false for at least one cycle.
- R7: Consider inputs sampled at rising edge k that form a match, where the previous sampled cycle was not a match. `trig_out` is then high in the cycle that follows rising edge k+1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_strobe | input | 1 | High during a valid bus access |
| addr_in | input | ADDR_W (16) | Monitored address field |
| data_in | input | DATA_W (8) | Monitored data field |
| pat_ref | input | ADDR_W+DATA_W (24) | Reference value per bus bit |
| pat_care | input | ADDR_W+DATA_W (24) | 1 = compare bit, 0 = bit reads as pulled-up 1 |
| trig_out | output | 1 | One-clock trigger pulse |

## Verification
The hardest situations to reach are a match that persists and the same persisting match cut by a reset. Both need the strobe and pattern held steady across many edges. The stimulus holds one matching access for several cycles and checks that only the first one pulses. It then drops the strobe for a single cycle to re-arm, and finally asserts reset in the middle of a held match to confirm that a fresh pulse follows release. The disabled-bit case with reference 0 is driven with bus values that agree bit for bit, so only the pull-up rule can explain the missing pulse.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } trig_state_e;

endpackage

// File: rtl/bpt_capture.sv
module bpt_capture #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_d,
    input  logic [W-1:0] bus_d,
    input  logic [W-1:0] ref_d,
    input  logic [W-1:0] care_d,
    output logic         strobe_q,
    output logic [W-1:0] bus_q,
    output logic [W-1:0] ref_q,
    output logic [W-1:0] care_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            bus_q    <= '0;
            ref_q    <= '0;
            care_q   <= '0;
        end else begin
            strobe_q <= strobe_d;
            bus_q    <= bus_d;
            ref_q    <= ref_d;
            care_q   <= care_d;
        end
    end

endmodule

// File: rtl/bpt_compare.sv
module bpt_compare #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_q,
    input  logic [W-1:0] bus_q,
    input  logic [W-1:0] ref_q,
    input  logic [W-1:0] care_q,
    output logic         match
);

    logic [W-1:0] pulled;
    logic [W-1:0] bit_hit;

    // Each bit: a disabled bit behaves like an open input with a pull-up.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pulled[i]  = care_q[i] ? bus_q[i] : 1'b1;
        assign bit_hit[i] = ~(pulled[i] ^ ref_q[i]);
    end

    assign match = strobe_q & (&bit_hit);

    assert_strobe_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |-> !match);

    assert_dontcare_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (|(~care_q & ~ref_q)) |-> !match);

endmodule

// File: rtl/bpt_edge_fsm.sv
module bpt_edge_fsm
    import bpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match,
    output logic trig
);

    trig_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (match)  state_nx = ST_FIRE;
            ST_FIRE: state_nx = match ? ST_HOLD : ST_WAIT;
            ST_HOLD: if (!match) state_nx = ST_WAIT;
            default: state_nx = ST_WAIT;
        endcase
    end

    always_comb begin
        trig = (state == ST_FIRE);
    end

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (rst)
        (match && $past(match)) |=> !trig);

endmodule

// File: rtl/bus_pattern_trigger.sv
module bus_pattern_trigger
    import bpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_strobe,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [DATA_W-1:0]        data_in,
    input  logic [ADDR_W+DATA_W-1:0] pat_ref,
    input  logic [ADDR_W+DATA_W-1:0] pat_care,
    output logic                     trig_out
);

    localparam int BUS_W = ADDR_W + DATA_W;

    logic             strobe_q;
    logic [BUS_W-1:0] bus_q;
    logic [BUS_W-1:0] ref_q;
    logic [BUS_W-1:0] care_q;
    logic             match;

    bpt_capture #(.W(BUS_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .strobe_d (bus_strobe),
        .bus_d    ({addr_in, data_in}),
        .ref_d    (pat_ref),
        .care_d   (pat_care),
        .strobe_q (strobe_q),
        .bus_q    (bus_q),
        .ref_q    (ref_q),
        .care_q   (care_q)
    );

    bpt_compare #(.W(BUS_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .strobe_q (strobe_q),
        .bus_q    (bus_q),
        .ref_q    (ref_q),
        .care_q   (care_q),
        .match    (match)
    );

    bpt_edge_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .match (match),
        .trig  (trig_out)
    );

    // R7: a pulse traces back to a strobe sampled two edges earlier
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(bus_strobe, 2));

endmodule

// File: tb/sim_bus_pattern_trigger.sv
module sim_bus_pattern_trigger;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int BW = AW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_strobe = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [BW-1:0] pat_ref = '0;
    logic [BW-1:0] pat_care = '0;
    logic          trig_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit    exp_q[$];
    string tag_q[$];
    bit    pend_v = 0;
    bit    pend_exp;
    string pend_tag;
    bit    model_prev = 0;

    always #5 clk = ~clk;

    bus_pattern_trigger #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_strobe (bus_strobe),
        .addr_in    (addr_in),
        .data_in    (data_in),
        .pat_ref    (pat_ref),
        .pat_care   (pat_care),
        .trig_out   (trig_out)
    );

    function automatic bit model_match(input bit acc, input logic [BW-1:0] word,
                                       input logic [BW-1:0] r, input logic [BW-1:0] c);
        bit ok = acc;
        for (int i = 0; i < BW; i++) begin
            if (c[i]) begin
                if (word[i] != r[i]) ok = 0;
            end else begin
                if (r[i] == 1'b0) ok = 0;
            end
        end
        return ok;
    endfunction

    task automatic drive(input bit acc, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] r, input logic [BW-1:0] c, input string tag);
        bit m;
        @(negedge clk);
        rst        = 1'b0;
        bus_strobe = acc;
        addr_in    = a;
        data_in    = d;
        pat_ref    = r;
        pat_care   = c;
        m = model_match(acc, {a, d}, r, c);
        exp_q.push_back(m && !model_prev);
        tag_q.push_back(tag);
        model_prev = m;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, '0, '0, tag);
    endtask

    // Monitor: compares the item popped one edge earlier (two-edge latency)
    always @(posedge clk) begin
        #1;
        if (rst) begin
            pend_v = 0;
            exp_q.delete();
            tag_q.delete();
        end else begin
            if (pend_v) begin
                checks++;
                if (trig_out !== pend_exp) begin
                    fails++;
                    $display("FAIL %s: trig_out=%0b expected %0b", pend_tag, trig_out, pend_exp);
                end
            end
            pend_v = 0;
            if (exp_q.size() > 0) begin
                pend_exp = exp_q.pop_front();
                pend_tag = tag_q.pop_front();
                pend_v   = 1;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: timeout actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [BW-1:0] ALL = {BW{1'b1}};

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (trig_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: trig_out=%0b expected 0 in reset", trig_out);
        end

        // R2: exact match, all bits compared; R7 latency via alignment
        drive(1'b1, 16'h1234, 8'h56, 24'h123456, ALL, "R2_R7 exact match");
        idle(2, "R2 after match");
        // R2: one address bit differs
        drive(1'b1, 16'h1235, 8'h56, 24'h123456, ALL, "R2 one bit off");
        idle(2, "R2 after miss");
        // R2: data bit differs
        drive(1'b1, 16'hA5A5, 8'h01, 24'hA5A500, ALL, "R2 data bit off");
        idle(1, "R2 idle");
        // R4: match but strobe low
        drive(1'b0, 16'h1234, 8'h56, 24'h123456, ALL, "R4 strobe low");
        idle(2, "R4 idle");
        // R3: data bits disabled with ref 1, data arbitrary
        drive(1'b1, 16'hBEEF, 8'h3C, 24'hBEEFFF, 24'hFFFF00, "R3 dontcare ref1");
        idle(2, "R3 idle");
        // R3: disabled bit with ref 0 never matches, even when bus agrees
        drive(1'b1, 16'hBEEF, 8'h00, 24'hBEEF00, 24'hFFFF00, "R3 dontcare ref0");
        idle(2, "R3 idle");
        drive(1'b1, 16'h0000, 8'h00, 24'h000000, 24'h000000, "R3 all off ref0");
        idle(1, "R3 idle");
        drive(1'b1, 16'h0000, 8'h00, ALL, 24'h000000, "R3 all off ref1");
        idle(2, "R3 idle");
        // R6/R5: held match pulses once
        for (int i = 0; i < 5; i++)
            drive(1'b1, 16'h4000, 8'h7E, 24'h40007E, ALL, "R6_R5 held match");
        // R6: one-cycle gap re-arms
        drive(1'b0, 16'h4000, 8'h7E, 24'h40007E, ALL, "R6 gap");
        drive(1'b1, 16'h4000, 8'h7E, 24'h40007E, ALL, "R6 rearm");
        drive(1'b1, 16'h4000, 8'h7E, 24'h40007E, ALL, "R6 rearm hold");
        // R6: back-to-back different matching accesses with masked address
        drive(1'b1, 16'h4001, 8'h7E, 24'hFFFF7E, 24'h0000FF, "R6 new addr no pulse");
        idle(2, "R6 idle");
        // R1: reset in the middle of a held match
        for (int i = 0; i < 3; i++)
            drive(1'b1, 16'h0F0F, 8'hF0, 24'h0F0FF0, ALL, "R1 pre-reset hold");
        @(negedge clk);
        rst = 1'b1;
        model_prev = 0;
        @(negedge clk);
        @(posedge clk);
        #2;
        checks++;
        if (trig_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: trig_out=%0b expected 0 during reset", trig_out);
        end
        for (int i = 0; i < 3; i++)
            drive(1'b1, 16'h0F0F, 8'hF0, 24'h0F0FF0, ALL, "R1 pulse after reset");
        idle(3, "R1 idle");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule